// File: doc/BRIEF.md
# Capture Input Conditioning Stage

This block turns four timer capture pins into four single-cycle capture-event strobes for a timer's capture registers. Each pin is brought into the block clock domain through a two-flop synchroniser and then passes through a glitch filter. The filter only changes its output after a selectable number of consecutive samples agree with the new level, and it samples on a clock enable that divides the block clock. Channel 0 can take either its own pin or the exclusive-OR of pins 0, 1 and 2 as its input.

Channels are grouped in pairs (0 with 1, 2 with 3). Each channel picks its capture trigger from three sources: the active edge of its own filtered pin, the active edge of its partner's filtered pin, or an externally supplied trigger-edge strobe. A per-channel polarity bit chooses between the rising and the falling edge. A per-channel prescaler then passes only one of every 1, 2, 4 or 8 selected events. A per-channel enable gates the output and clears the prescaler.

Top module: `cap_cond_stage`

## Requirements
- R1: With filter code 0, a rising edge on an enabled channel's own pin, set up before clock edge k, raises `cap_evt_o` for exactly one cycle, right after edge k+2.
- R2: `flt_sel` codes 0,1,2,3,4,5 select a required run of 0,2,4,5,6,8 consecutive samples (6 and 7 also select 8). The filtered level changes only after that many consecutive samples differ from it, and a shorter pulse produces no event. Code 0 bypasses the filter.
- R3: The filter samples only on the sampling tick, which occurs once every `samp_div`+1 block clocks. A pulse that spans fewer ticks than the required run is rejected even when it is long enough in clock cycles.
- R4: When `xor_sel` is 1, channel 0's input is pin0 XOR pin1 XOR pin2; when it is 0, channel 0 uses pin 0 only.
- R5: `pol` bit i clear makes the rising edge of the selected filtered signal the active edge of channel i. When it is set, the falling edge is the active edge.
- R6: `src_sel` field i (bits 2i+1:2i) selects the capture source: 0 = own pin, 1 = partner pin (partner of i is i XOR 1), 2 = the `trig_i` strobe, 3 = own pin. An edge on the partner pin uses channel i's own polarity.
- R7: `psc_sel` field i (bits 2i+1:2i) codes 0..3 pass 1 of every 1, 2, 4, 8 selected events. The first event after the prescaler is cleared produces a pulse.
- R8: The prescaler counter clears when its channel is disabled or its `psc_sel` field changes.
- R9: `cap_evt_o` is 0 after reset. Channel i produces no pulse while `ch_en[i]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 4 | Raw capture pins, asynchronous |
| samp_div | input | 4 | Sampling tick every samp_div+1 clocks |
| xor_sel | input | 1 | Channel 0 uses XOR of pins 0..2 |
| flt_sel | input | 12 | 3-bit filter code per channel |
| pol | input | 4 | Active-edge polarity per channel (1 = falling) |
| src_sel | input | 8 | 2-bit capture source per channel |
| psc_sel | input | 8 | 2-bit prescale code per channel |
| ch_en | input | 4 | Per-channel enable |
| trig_i | input | 1 | Trigger-edge strobe, shared |
| cap_evt_o | output | 4 | One-cycle capture-event pulse per channel |

## Verification
The filter gets pulses exactly one sample shorter than the required run and pulses of exactly the required length, for two run lengths. This separates an off-by-one in the run counter from a correct one. The same short pulse is repeated with a slow sampling tick, which shows that samples are counted on the tick and not on clocks. Source, XOR and polarity tests drive one pin at a time and look for events on the channel that should react and on the one that should not. Prescaler tests count strobes against 1-in-N ratios, and a mid-count setting change or disable shows whether the counter is really cleared.

// File: rtl/cap_cond_pkg.sv
package cap_cond_pkg;

  typedef enum logic [1:0] {
    SRC_OWN     = 2'd0,
    SRC_PARTNER = 2'd1,
    SRC_TRIG    = 2'd2,
    SRC_OWN_ALT = 2'd3
  } cap_src_e;

  // Required consecutive-sample run for a filter code (0 = bypass).
  function automatic logic [3:0] run_len(input logic [2:0] code);
    case (code)
      3'd0:    run_len = 4'd0;
      3'd1:    run_len = 4'd2;
      3'd2:    run_len = 4'd4;
      3'd3:    run_len = 4'd5;
      3'd4:    run_len = 4'd6;
      default: run_len = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/cap_glitch_filter.sv
module cap_glitch_filter
  import cap_cond_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       samp_tick,
  input  logic [2:0] code_i,
  input  logic       sync_i,
  output logic       filt_o
);
  logic [3:0] need;
  logic [3:0] cnt_q, cnt_d;
  logic       lvl_q, lvl_d;

  assign need = run_len(code_i);

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (need == 4'd0) begin
      cnt_d = '0;
      lvl_d = sync_i;
    end else if (samp_tick) begin
      if (sync_i == lvl_q) begin
        cnt_d = '0;
      end else if (cnt_q >= need - 4'd1) begin
        cnt_d = '0;
        lvl_d = sync_i;
      end else begin
        cnt_d = cnt_q + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign filt_o = (need == 4'd0) ? sync_i : lvl_q;

  // R3: with filtering active, the level holds between sampling ticks
  assert_hold_off_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!samp_tick && need != 4'd0) |=> (lvl_q == $past(lvl_q)));

  // R2: a sample matching the current level restarts the run count
  assert_match_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_tick && need != 4'd0 && sync_i == lvl_q) |=> (cnt_q == 4'd0));
endmodule

// File: rtl/cap_prescaler.sv
module cap_prescaler #(
  parameter int SEL_W = 2,
  localparam int CW   = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             evt_i,
  output logic             pass_o
);
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [SEL_W-1:0] sel_q;
  logic [CW-1:0]    last;
  logic             chg;

  assign last = CW'((1 << sel_i) - 1);
  assign chg  = (sel_i != sel_q);

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i || chg)      cnt_d = '0;
    else if (evt_i)        cnt_d = (cnt_q >= last) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      sel_q <= sel_i;
    end
  end

  assign pass_o = en_i && evt_i && (cnt_q == '0);

  // R8: disable or a new prescale setting leaves the counter at zero
  assert_psc_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i || chg) |=> (cnt_q == '0));
endmodule

// File: rtl/cap_cond_stage.sv
module cap_cond_stage
  import cap_cond_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int DIV_W = 4,
  parameter int FLT_W = 3,
  parameter int PSC_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     pin_i,
  input  logic [DIV_W-1:0]   samp_div,
  input  logic               xor_sel,
  input  logic [NCH*FLT_W-1:0] flt_sel,
  input  logic [NCH-1:0]     pol,
  input  logic [NCH*2-1:0]   src_sel,
  input  logic [NCH*PSC_W-1:0] psc_sel,
  input  logic [NCH-1:0]     ch_en,
  input  logic               trig_i,
  output logic [NCH-1:0]     cap_evt_o
);
  logic [NCH-1:0]   sync_w;
  logic [NCH-1:0]   flt_in;
  logic [NCH-1:0]   filt_w;
  logic [NCH-1:0]   filt_prev_q;
  logic [NCH-1:0]   sel_evt;
  logic [NCH-1:0]   pass_w;
  logic [NCH-1:0]   evt_q;
  logic [DIV_W-1:0] div_cnt_q, div_cnt_d;
  logic             samp_tick;

  // Sampling clock enable
  assign samp_tick = (div_cnt_q >= samp_div);
  always_comb div_cnt_d = samp_tick ? '0 : div_cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt_q <= '0;
    else        div_cnt_q <= div_cnt_d;
  end

  cap_sync #(.W(NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(sync_w)
  );

  // Channel 0 optional three-pin XOR source
  always_comb begin
    flt_in = sync_w;
    if (xor_sel) flt_in[0] = sync_w[0] ^ sync_w[1] ^ sync_w[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_prev_q <= '0;
      evt_q       <= '0;
    end else begin
      filt_prev_q <= filt_w;
      evt_q       <= pass_w;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int P = i ^ 1;
    logic own_edge, part_edge;
    cap_src_e src;

    cap_glitch_filter u_flt (
      .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick),
      .code_i(flt_sel[i*FLT_W +: FLT_W]), .sync_i(flt_in[i]), .filt_o(filt_w[i])
    );

    assign own_edge  = pol[i] ? (filt_prev_q[i] & ~filt_w[i]) : (filt_w[i] & ~filt_prev_q[i]);
    assign part_edge = pol[i] ? (filt_prev_q[P] & ~filt_w[P]) : (filt_w[P] & ~filt_prev_q[P]);
    assign src       = cap_src_e'(src_sel[i*2 +: 2]);

    always_comb begin
      case (src)
        SRC_PARTNER: sel_evt[i] = part_edge;
        SRC_TRIG:    sel_evt[i] = trig_i;
        default:     sel_evt[i] = own_edge;
      endcase
    end

    cap_prescaler #(.SEL_W(PSC_W)) u_psc (
      .clk(clk), .rst_n(rst_n), .en_i(ch_en[i]),
      .sel_i(psc_sel[i*PSC_W +: PSC_W]), .evt_i(sel_evt[i]), .pass_o(pass_w[i])
    );

    // R9: a strobe only follows a cycle in which the channel was enabled
    assert_en_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt_o[i] |-> $past(ch_en[i]));

    // R6: trigger source with no prescaling forwards the strobe next cycle
    assert_trig_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en[i] && src == SRC_TRIG && trig_i && psc_sel[i*PSC_W +: PSC_W] == '0
       && $stable(psc_sel[i*PSC_W +: PSC_W]) && $past(ch_en[i])) |=> cap_evt_o[i]);
  end

  assign cap_evt_o = evt_q;
endmodule

// File: tb/cap_cond_stage_tb.sv
`timescale 1ns/1ps
module cap_cond_stage_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] pin_i;
  logic [3:0] samp_div;
  logic       xor_sel;
  logic [11:0] flt_sel;
  logic [3:0] pol;
  logic [7:0] src_sel;
  logic [7:0] psc_sel;
  logic [3:0] ch_en;
  logic       trig_i;
  logic [3:0] cap_evt_o;

  int checks = 0;
  int errors = 0;
  int evt_cnt [4];

  always #5 clk = ~clk;

  cap_cond_stage u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .samp_div(samp_div),
    .xor_sel(xor_sel), .flt_sel(flt_sel), .pol(pol), .src_sel(src_sel),
    .psc_sel(psc_sel), .ch_en(ch_en), .trig_i(trig_i), .cap_evt_o(cap_evt_o)
  );

  always @(negedge clk)
    if (rst_n) for (int i = 0; i < 4; i++) evt_cnt[i] += int'(cap_evt_o[i]);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_pin(input int ch, input int len);
    @(negedge clk); pin_i[ch] = 1'b1;
    idle(len);
    pin_i[ch] = 1'b0;
    idle(30);
  endtask

  task automatic send_trig(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); trig_i = 1'b1;
      @(negedge clk); trig_i = 1'b0;
      idle(2);
    end
    idle(3);
  endtask

  task automatic defaults();
    @(negedge clk);
    xor_sel = 0; flt_sel = '0; pol = '0; src_sel = '0; psc_sel = '0;
    samp_div = '0; ch_en = '0; trig_i = 0; pin_i = '0;
    idle(20);
  endtask

  task automatic t_reset();
    check("R9 reset output", int'(cap_evt_o), 0);
  endtask

  task automatic t_latency();
    defaults();
    ch_en = 4'b0001;
    idle(3);
    @(negedge clk); pin_i[0] = 1'b1;        // before edge k
    @(posedge clk); @(posedge clk);          // edges k, k+1
    @(negedge clk); check("R1 no pulse before k+2", int'(cap_evt_o[0]), 0);
    @(negedge clk); check("R1 pulse after k+2", int'(cap_evt_o[0]), 1);
    @(negedge clk); check("R1 pulse one cycle", int'(cap_evt_o[0]), 0);
    begin
      int b = evt_cnt[0];
      pin_i[0] = 1'b0; idle(20);
      check("R5 falling edge ignored at pol 0", evt_cnt[0] - b, 0);
    end
  endtask

  task automatic t_filter();
    int b;
    defaults();
    ch_en = 4'b0100;
    flt_sel[8:6] = 3'd2;                     // run of 4
    b = evt_cnt[2]; pulse_pin(2, 3);
    check("R2 run4 rejects 3", evt_cnt[2] - b, 0);
    b = evt_cnt[2]; pulse_pin(2, 4);
    check("R2 run4 accepts 4", evt_cnt[2] - b, 1);
    flt_sel[8:6] = 3'd5;                     // run of 8
    idle(5);
    b = evt_cnt[2]; pulse_pin(2, 7);
    check("R2 run8 rejects 7", evt_cnt[2] - b, 0);
    b = evt_cnt[2]; pulse_pin(2, 8);
    check("R2 run8 accepts 8", evt_cnt[2] - b, 1);
    flt_sel[8:6] = 3'd3;                     // run of 5
    idle(5);
    b = evt_cnt[2]; pulse_pin(2, 4);
    check("R2 run5 rejects 4", evt_cnt[2] - b, 0);
  endtask

  task automatic t_sampling();
    int b;
    defaults();
    ch_en = 4'b0100;
    flt_sel[8:6] = 3'd1;                     // run of 2
    b = evt_cnt[2]; pulse_pin(2, 3);
    check("R3 tick every clock accepts 3", evt_cnt[2] - b, 1);
    samp_div = 4'd3;
    idle(5);
    b = evt_cnt[2]; pulse_pin(2, 3);
    check("R3 slow tick rejects 3 clocks", evt_cnt[2] - b, 0);
    b = evt_cnt[2]; pulse_pin(2, 16);
    check("R3 slow tick accepts 16 clocks", evt_cnt[2] - b, 1);
  endtask

  task automatic t_xor();
    int b;
    defaults();
    ch_en = 4'b0001;
    b = evt_cnt[0];
    @(negedge clk); pin_i[1] = 1; idle(10);
    check("R4 pin1 ignored without xor", evt_cnt[0] - b, 0);
    pin_i[1] = 0; idle(10);
    xor_sel = 1; idle(10);
    b = evt_cnt[0];
    pin_i[1] = 1; idle(10);
    check("R4 xor rises on pin1", evt_cnt[0] - b, 1);
    pin_i[2] = 1; idle(10);
    check("R4 xor falls on pin2", evt_cnt[0] - b, 1);
    pin_i[0] = 1; idle(10);
    check("R4 xor rises on pin0", evt_cnt[0] - b, 2);
  endtask

  task automatic t_polarity();
    int b;
    defaults();
    ch_en = 4'b0010; pol = 4'b0010;
    idle(5);
    b = evt_cnt[1];
    @(negedge clk); pin_i[1] = 1; idle(15);
    check("R5 pol1 no rising event", evt_cnt[1] - b, 0);
    pin_i[1] = 0; idle(15);
    check("R5 pol1 falling event", evt_cnt[1] - b, 1);
  endtask

  task automatic t_source();
    int b1, b3;
    defaults();
    ch_en = 4'b1010; src_sel = 8'b01_00_01_00;   // ch1, ch3 = partner
    b1 = evt_cnt[1]; pulse_pin(0, 5);
    check("R6 ch1 follows pin0", evt_cnt[1] - b1, 1);
    b1 = evt_cnt[1]; pulse_pin(1, 5);
    check("R6 ch1 ignores own pin", evt_cnt[1] - b1, 0);
    b3 = evt_cnt[3]; pulse_pin(2, 5);
    check("R6 ch3 follows pin2", evt_cnt[3] - b3, 1);
    pol[1] = 1; idle(5);
    b1 = evt_cnt[1];
    @(negedge clk); pin_i[0] = 1; idle(15);
    check("R6 partner uses own polarity rise", evt_cnt[1] - b1, 0);
    pin_i[0] = 0; idle(15);
    check("R6 partner uses own polarity fall", evt_cnt[1] - b1, 1);
    pol = '0; src_sel = 8'b00_00_10_00;         // ch1 = trigger
    idle(5);
    b1 = evt_cnt[1]; send_trig(1);
    check("R6 trigger source", evt_cnt[1] - b1, 1);
    b1 = evt_cnt[1]; pulse_pin(1, 5);
    check("R6 trigger ignores pin", evt_cnt[1] - b1, 0);
    src_sel = 8'b00_00_11_00; idle(5);          // code 3 = own
    b1 = evt_cnt[1]; pulse_pin(1, 5);
    check("R6 code 3 own pin", evt_cnt[1] - b1, 1);
  endtask

  task automatic t_prescale();
    int b;
    defaults();
    ch_en = 4'b1000; src_sel = 8'b10_00_00_00;
    psc_sel[7:6] = 2'd1; idle(3);
    b = evt_cnt[3]; send_trig(5);
    check("R7 div2 of 5", evt_cnt[3] - b, 3);
    psc_sel[7:6] = 2'd2; idle(3);
    b = evt_cnt[3]; send_trig(9);
    check("R7 div4 of 9", evt_cnt[3] - b, 3);
    psc_sel[7:6] = 2'd3; idle(3);
    b = evt_cnt[3]; send_trig(9);
    check("R7 div8 of 9", evt_cnt[3] - b, 2);
    psc_sel[7:6] = 2'd2; idle(3);
    send_trig(2);                               // counter now mid-count
    psc_sel[7:6] = 2'd1; idle(3);
    b = evt_cnt[3]; send_trig(1);
    check("R8 setting change clears count", evt_cnt[3] - b, 1);
    psc_sel[7:6] = 2'd2; idle(3);
    send_trig(1);
    ch_en = 4'b0000; idle(3);
    ch_en = 4'b1000; idle(3);
    b = evt_cnt[3]; send_trig(1);
    check("R8 disable clears count", evt_cnt[3] - b, 1);
    ch_en = 4'b0000; idle(3);
    b = evt_cnt[3]; send_trig(4);
    check("R9 disabled channel silent", evt_cnt[3] - b, 0);
  endtask

  initial begin
    rst_n = 0; pin_i = '0; samp_div = '0; xor_sel = 0; flt_sel = '0;
    pol = '0; src_sel = '0; psc_sel = '0; ch_en = '0; trig_i = 0;
    for (int i = 0; i < 4; i++) evt_cnt[i] = 0;
    idle(4);
    rst_n = 1;
    idle(2);
    t_reset();
    t_latency();
    t_filter();
    t_sampling();
    t_xor();
    t_polarity();
    t_source();
    t_prescale();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule